// File: doc/BRIEF.md
# PPS Period Monitor

The block watches an external once-per-second pulse on the streaming clock and keeps software informed of how regular that pulse is. The pulse input is first sampled on either the rising or the falling clock edge, chosen by software, then passed through a synchroniser, and each 0-to-1 transition of the synchronised level counts as one captured pulse. A free-running counter measures the number of clock cycles between consecutive captured pulses; each completed period is latched, compared against a programmable expected count, and folded into a sticky stability flag that software re-arms by reading the status word.

Software accesses three 32-bit words through a simple strobe interface with a word address. Word 0 reports the last period, the stability flag and a level that flips on every pulse; word 1 holds the expected period and the sampling-edge select; word 2 returns the live cycle count since the most recent pulse. Read data is registered and appears one clock after the read strobe.

Top module: `pps_period_monitor`

## Requirements
- R1: After reset, status word (word address 0) reads 0x3FFFFFFF masked to the counter width (period field at its maximum, bit 30 stable = 0, bit 31 toggle = 0), the control word reads 0, and the offset word reads the counter maximum.
- R2: Status bits [29:0] hold the number of clock cycles between the two most recent captured pulses; bits of the field above the counter width read 0.
- R3: Status bit 30 reads 1 only if every period captured since the previous status read equalled the expected count; a single differing period makes it read 0.
- R4: A status read re-arms the stability evaluation: a period that completes in or after the read cycle is judged for the next read, and with no period completed in between the next read shows 1.
- R5: Status bit 31 inverts on every captured pulse and is otherwise constant.
- R6: The control word (word address 1) is read/write: bits [CNT_W-1:0] hold the expected period, bit 31 the sampling edge (0 = rising clock edge, 1 = falling clock edge); all other bits read 0.
- R7: Word address 2 returns the cycles since the last captured pulse, sampled at the read strobe. With edge select 0 a pulse input rising just after clock edge e0 restarts this count at edge e4 (read sampled at edge ej returns j-4); with edge select 1 the restart is at e3 (returns j-3).
- R8: Writes to word addresses 0 and 2 have no effect on any register.
- R9: The offset counter and the captured period saturate at their maximum value (all ones over CNT_W bits) instead of wrapping.
- R10: A read strobe produces its data and a one-cycle read-valid pulse on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Streaming clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ppsIn | input | 1 | External pulse-per-second level |
| regAddr | input | 2 | Word address of the access |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 32 | Write data |
| regRdEn | input | 1 | Read strobe, one cycle per read |
| regRdData | output | 32 | Registered read data |
| regRdValid | output | 1 | High one cycle after a read strobe |

## Verification
The assertions assume the pulse input stays high for at least two clock cycles per pulse and that register strobes last a single cycle with a stable address, so that each pulse produces exactly one detection and each read re-arms exactly once. The stimulus raises the pulse shortly after a rising clock edge, holds it high for two cycles, spaces pulses far beyond the synchroniser depth, and changes the edge select only while the pulse input is low, so no switch of the sampling path can fabricate an edge.

// File: rtl/pps_mon_pkg.sv
package pps_mon_pkg;

  localparam int REG_W   = 32;
  localparam int FIELD_W = 30;

  typedef enum logic [1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_CTRL   = 2'd1,
    ADDR_OFFSET = 2'd2,
    ADDR_SPARE  = 2'd3
  } reg_addr_e;

  // Strobes and settings handed from the register side to the datapath
  typedef struct packed {
    logic rearm;     // status word read this cycle
    logic fallEdge;  // sample the pulse on the falling clock edge
  } pps_ctl_t;

endpackage

// File: rtl/pps_mon_dp.sv
module pps_mon_dp
  import pps_mon_pkg::*;
#(
  parameter int CNT_W       = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ppsIn,
  input  pps_ctl_t         ctl,
  input  logic [CNT_W-1:0] expected,
  output logic [CNT_W-1:0] periodCnt,
  output logic [CNT_W-1:0] offsetCnt,
  output logic             stableFlag,
  output logic             toggleFlag
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic riseSample;
  logic fallSample;
  logic edgeSample;
  logic [SYNC_STAGES-1:0] syncChain;
  logic syncPrev;
  logic ppsPulse;
  logic periodMatch;

  // Edge-selectable input capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) riseSample <= 1'b0;
    else       riseSample <= ppsIn;
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) fallSample <= 1'b0;
    else       fallSample <= ppsIn;
  end

  assign edgeSample = ctl.fallEdge ? fallSample : riseSample;

  // Synchroniser and rising-transition detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
      syncPrev  <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], edgeSample};
      syncPrev  <= syncChain[SYNC_STAGES-1];
    end
  end

  assign ppsPulse    = syncChain[SYNC_STAGES-1] & ~syncPrev;
  assign periodMatch = (offsetCnt == expected);

  // Cycles since last pulse, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    offsetCnt <= CNT_MAX;
    else if (ppsPulse)            offsetCnt <= CNT_ONE;
    else if (offsetCnt != CNT_MAX) offsetCnt <= offsetCnt + CNT_ONE;
  end

  // Period capture and toggle level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt  <= CNT_MAX;
      toggleFlag <= 1'b0;
    end else if (ppsPulse) begin
      periodCnt  <= offsetCnt;
      toggleFlag <= ~toggleFlag;
    end
  end

  // Sticky stability evaluation, re-armed by a status read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stableFlag <= 1'b0;
    else       stableFlag <= (ctl.rearm | stableFlag) & (~ppsPulse | periodMatch);
  end

  AST_PERIOD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    ppsPulse |=> periodCnt == $past(offsetCnt)); // R2
  AST_MISMATCH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (ppsPulse && offsetCnt != expected) |=> !stableFlag); // R3
  AST_REARM_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rearm && !ppsPulse) |=> stableFlag); // R4
  AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ppsPulse |=> $stable(toggleFlag)); // R5
  AST_OFFSET_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    ppsPulse |=> offsetCnt == CNT_ONE); // R7
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!ppsPulse && offsetCnt == CNT_MAX) |=> offsetCnt == CNT_MAX); // R9

endmodule

// File: rtl/pps_mon_ctrl.sv
module pps_mon_ctrl
  import pps_mon_pkg::*;
#(
  parameter int CNT_W = 30
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             regRdEn,
  output logic [REG_W-1:0] regRdData,
  output logic             regRdValid,
  output pps_ctl_t         ctl,
  output logic [CNT_W-1:0] expected,
  input  logic [CNT_W-1:0] periodCnt,
  input  logic [CNT_W-1:0] offsetCnt,
  input  logic             stableFlag,
  input  logic             toggleFlag
);

  reg_addr_e           addrDec;
  logic                ctrlEdge;
  logic [CNT_W-1:0]    ctrlExp;
  logic [REG_W-1:0]    rdMux;
  logic [FIELD_W-1:0]  periodField;
  logic [FIELD_W-1:0]  offsetField;
  logic [FIELD_W-1:0]  expField;
  logic                unusedWrBits;

  assign addrDec      = reg_addr_e'(regAddr);
  assign unusedWrBits = ^regWrData[REG_W-2:CNT_W];

  // Control word storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlExp  <= '0;
      ctrlEdge <= 1'b0;
    end else if (regWrEn && addrDec == ADDR_CTRL) begin
      ctrlExp  <= regWrData[CNT_W-1:0];
      ctrlEdge <= regWrData[REG_W-1];
    end
  end

  assign expected     = ctrlExp;
  assign ctl.fallEdge = ctrlEdge;
  assign ctl.rearm    = regRdEn && (addrDec == ADDR_STATUS);

  assign periodField = FIELD_W'(periodCnt);
  assign offsetField = FIELD_W'(offsetCnt);
  assign expField    = FIELD_W'(ctrlExp);

  always_comb begin
    case (addrDec)
      ADDR_STATUS: rdMux = {toggleFlag, stableFlag, periodField};
      ADDR_CTRL:   rdMux = {ctrlEdge, 1'b0, expField};
      ADDR_OFFSET: rdMux = {2'b00, offsetField};
      default:     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdData  <= '0;
      regRdValid <= 1'b0;
    end else begin
      regRdValid <= regRdEn;
      if (regRdEn) regRdData <= rdMux;
    end
  end

  AST_RDVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> regRdValid); // R10
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == 2'd1) |=> ($stable(ctrlExp) && $stable(ctrlEdge))); // R8

endmodule

// File: rtl/pps_period_monitor.sv
module pps_period_monitor
  import pps_mon_pkg::*;
#(
  parameter int CNT_W       = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ppsIn,
  input  logic [1:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  input  logic        regRdEn,
  output logic [31:0] regRdData,
  output logic        regRdValid
);

  pps_ctl_t         ctl;
  logic [CNT_W-1:0] expected;
  logic [CNT_W-1:0] periodCnt;
  logic [CNT_W-1:0] offsetCnt;
  logic             stableFlag;
  logic             toggleFlag;

  pps_mon_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .regRdEn    (regRdEn),
    .regRdData  (regRdData),
    .regRdValid (regRdValid),
    .ctl        (ctl),
    .expected   (expected),
    .periodCnt  (periodCnt),
    .offsetCnt  (offsetCnt),
    .stableFlag (stableFlag),
    .toggleFlag (toggleFlag)
  );

  pps_mon_dp #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ppsIn      (ppsIn),
    .ctl        (ctl),
    .expected   (expected),
    .periodCnt  (periodCnt),
    .offsetCnt  (offsetCnt),
    .stableFlag (stableFlag),
    .toggleFlag (toggleFlag)
  );

endmodule

// File: tb/pps_period_monitor_tb.sv
module pps_period_monitor_tb;

  localparam int CNT_W = 10;
  localparam logic [31:0] CMAX = 32'h0000_03FF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ppsIn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = 32'd0;
  logic        regRdEn = 1'b0;
  logic [31:0] regRdData;
  logic        regRdValid;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  pps_period_monitor #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .ppsIn(ppsIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn),
    .regRdData(regRdData), .regRdValid(regRdValid)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pad(input int n);
    repeat (n) tick();
  endtask

  task automatic regWr(input logic [1:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a; regRdEn = 1'b1;
    tick();
    d = regRdData;
    check("R10 read valid", {31'd0, regRdValid}, 32'd1);
    regRdEn = 1'b0;
  endtask

  // Pulse high for two cycles, window of p cycles in total
  task automatic ppsPulse(input int p);
    ppsIn = 1'b1;
    tick(); tick();
    ppsIn = 1'b0;
    repeat (p - 2) tick();
  endtask

  task automatic testReset();
    logic [31:0] d;
    regRd(2'd0, d); check("R1 status after reset", d, CMAX);
    regRd(2'd1, d); check("R1 control after reset", d, 32'd0);
    regRd(2'd2, d); check("R1 offset after reset", d, CMAX);
  endtask

  task automatic testRegisters();
    logic [31:0] d;
    regWr(2'd1, 32'hFFFF_FC32);
    regRd(2'd1, d); check("R6 control readback", d, 32'h8000_0032);
    regWr(2'd0, 32'hFFFF_FFFF);
    regWr(2'd2, 32'h0000_0000);
    regRd(2'd1, d); check("R8 control untouched", d, 32'h8000_0032);
    // stable re-armed by previous status read, no period since: R4
    regRd(2'd0, d); check("R8 status untouched", d, 32'h4000_03FF);
    regWr(2'd1, 32'h0000_0032);
  endtask

  task automatic testStability();
    logic [31:0] d;
    ppsPulse(49);
    regRd(2'd0, d); check("R3 first period saturated, not stable", d, 32'h8000_03FF);
    ppsPulse(50);
    ppsPulse(10);
    regRd(2'd0, d); check("R2 period 50, stable, toggle", d, 32'hC000_0032);
    regRd(2'd0, d); check("R4 rearm without new period", d, 32'hC000_0032);
    pad(38);
    ppsPulse(60);
    ppsPulse(50);
    ppsPulse(10);
    regRd(2'd0, d); check("R3 one mismatch clears stable, R5 toggle", d, 32'h0000_0032);
    pad(39);
    ppsPulse(10);
    regRd(2'd0, d); check("R4 next read judges new periods only", d, 32'hC000_0032);
  endtask

  task automatic testEdge();
    logic [31:0] d;
    pad(60);
    ppsPulse(10);
    regRd(2'd2, d); check("R7 offset rising edge", d, 32'd7);
    regWr(2'd1, 32'h8000_0032);
    pad(60);
    ppsPulse(10);
    regRd(2'd2, d); check("R7 offset falling edge", d, 32'd8);
    regWr(2'd1, 32'h0000_0032);
  endtask

  task automatic testSaturation();
    logic [31:0] d;
    pad(1100);
    regRd(2'd2, d); check("R9 offset saturates", d, CMAX);
    ppsPulse(10);
    regRd(2'd0, d); check("R9 period saturates", d & 32'h3FFF_FFFF, CMAX);
    regRd(2'd2, d); check("R9 offset restarts after pulse", d, 32'd8);
  endtask

  initial begin
    #1;
    pad(4);
    rstN = 1'b1;
    tick();
    testReset();
    testRegisters();
    testStability();
    testEdge();
    testSaturation();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule